// File: doc/BRIEF.md
# Eight-Point Parallel Heat Stencil Stepper

This block advances a one-dimensional explicit heat-diffusion mesh of eight points by a whole time step in a single clock cycle. It first fetches the starting row from a single-port style RAM into an internal bank of eight operand registers. Six identical fixed-point kernels then recompute every interior point at once, and their outputs go straight back into the operand bank. Each later step therefore starts from registers and needs no memory reads. The two end points act as fixed boundary values.

A host puts the initial row at RAM addresses 0 to 7 and sets the step count, the diffusion coefficient and the mode bit. It then pulses `start`. The block can write every computed row back through its one write port, or, in final-only mode, only the last row. It counts the clock cycles it spends busy, so the host can read the processing time after `done`.

Top module: `heat_mesh_stepper`

## Requirements
- R1: After reset, `busy`, `done`, `rd_en` and `wr_en` are low and `cycles` is zero.
- R2: After `start`, the block reads addresses 0,1,...,7 in that order, one per cycle, with `rd_en` high. Read data is taken one cycle after its address, and these are the only reads of the run.
- R3: Each step replaces every interior value u (points 1 to 6) with u + ((c*(l - 2u + r)) >>> FRAC), using arithmetic shift and wrapping to W bits. Here l and r are the neighbours from the previous step and c is the signed coefficient, with FRAC=8 by default. All six points update together.
- R4: Points 0 and 7 keep their loaded values for the whole run, and every stored row carries them unchanged.
- R5: When `final_only` is low, step n (counting from 0) writes its row to addresses (n+1)*8+k with the value of point k. The writes go in order k=0..7, one per cycle, at consecutive addresses, for 8N writes in total.
- R6: When `final_only` is high, only the row after the last step is written, to addresses 8..15, which gives exactly 8 writes.
- R7: With a step count of zero, the block loads the row, makes no writes and raises `done`.
- R8: `busy` is high from the cycle after `start` is taken up to and including the single cycle in which `done` is high. `done` then falls and `busy` falls with it.
- R9: After `done`, `cycles` holds the number of busy cycles until the next start: 10+9N in normal mode, 18+N in final-only mode with N≥1, and 10 when N=0.
- R10: `start`, `steps`, `coef` and `final_only` are sampled only when the block is idle. Changes to them while busy do not affect the results, the writes or the cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run when idle |
| steps | input | NW (8) | Number of time steps N |
| coef | input | CW (16) | Signed diffusion coefficient, FRAC fraction bits |
| final_only | input | 1 | 1: store only the last row |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | RAM read request |
| rd_addr | output | AW (11) | RAM read address |
| rd_data | input | W (16) | RAM read data, one cycle after the request |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | AW (11) | RAM write address |
| wr_data | output | W (16) | RAM write data |
| cycles | output | CYW (32) | Busy-cycle count of the latest run |

## Verification
The properties assume the memory answers a read exactly one cycle after `rd_en`. They also assume the host waits for `done` before expecting a new run. Neither read nor write traffic is checked against the host's choice of addresses. The bench models a RAM with that one-cycle latency and fills all of it with random data before every run. It draws step counts, coefficients (mostly between 0 and 0.5) and modes from a seeded generator, and adds directed runs for zero steps, one step, the largest step count, a negative coefficient and input changes while busy. Wrapping arithmetic is modelled exactly, so overflowing cases need no constraint.

// File: rtl/heat_mesh_pkg.sv
package heat_mesh_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOAD,
        PH_STEP,
        PH_SAVE,
        PH_FIN
    } phase_e;

endpackage

// File: rtl/mesh_pe.sv
module mesh_pe #(
    parameter int W    = 16,
    parameter int CW   = 16,
    parameter int FRAC = 8
) (
    input  logic signed [W-1:0]  left,
    input  logic signed [W-1:0]  mid,
    input  logic signed [W-1:0]  right,
    input  logic signed [CW-1:0] coef,
    output logic signed [W-1:0]  nxt
);
    localparam int LW = W + 2;
    localparam int PW = LW + CW;

    logic signed [LW-1:0] l_x, m_x, r_x, lap;
    logic signed [PW-1:0] lap_x, c_x, prod, scaled;

    always_comb begin
        l_x    = {{2{left[W-1]}}, left};
        m_x    = {{2{mid[W-1]}}, mid};
        r_x    = {{2{right[W-1]}}, right};
        lap    = l_x + r_x - (m_x <<< 1);
        lap_x  = {{CW{lap[LW-1]}}, lap};
        c_x    = {{LW{coef[CW-1]}}, coef};
        prod   = lap_x * c_x;
        scaled = prod >>> FRAC;
        nxt    = mid + scaled[W-1:0];
    end

endmodule

// File: rtl/mesh_regbank.sv
module mesh_regbank #(
    parameter int NPTS = 8,
    parameter int W    = 16,
    localparam int IDXW = $clog2(NPTS),
    localparam int NI   = NPTS - 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_en,
    input  logic [IDXW-1:0]         load_idx,
    input  logic [W-1:0]            load_data,
    input  logic                    step_en,
    input  logic [NI-1:0][W-1:0]    step_vals,
    output logic [NPTS-1:0][W-1:0]  regs
);
    logic [NPTS-1:0][W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (load_en) begin
            regs_d[load_idx] = load_data;
        end else if (step_en) begin
            for (int k = 1; k < NPTS - 1; k++) begin
                regs_d[k] = step_vals[k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    // R4: a step never touches the two boundary registers
    a_r4_edges_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en) |=> (regs_q[0] == $past(regs_q[0])) &&
                                  (regs_q[NPTS-1] == $past(regs_q[NPTS-1])));

endmodule

// File: rtl/heat_mesh_stepper.sv
module heat_mesh_stepper
    import heat_mesh_pkg::*;
#(
    parameter int NPTS = 8,
    parameter int W    = 16,
    parameter int CW   = 16,
    parameter int FRAC = 8,
    parameter int NW   = 8,
    parameter int CYW  = 32,
    localparam int AW  = NW + $clog2(NPTS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [NW-1:0]  steps,
    input  logic [CW-1:0]  coef,
    input  logic           final_only,
    output logic           busy,
    output logic           done,
    output logic           rd_en,
    output logic [AW-1:0]  rd_addr,
    input  logic [W-1:0]   rd_data,
    output logic           wr_en,
    output logic [AW-1:0]  wr_addr,
    output logic [W-1:0]   wr_data,
    output logic [CYW-1:0] cycles
);
    localparam int IDXW = $clog2(NPTS);
    localparam int CNTW = $clog2(NPTS + 1);
    localparam int NI   = NPTS - 2;
    localparam logic [CNTW-1:0] CNT_FULL = CNTW'(NPTS);
    localparam logic [CNTW-1:0] CNT_LAST = CNTW'(NPTS - 1);
    localparam logic [CNTW-1:0] CNT_ONE  = CNTW'(1);
    localparam logic [NW-1:0]   STEP_ONE = NW'(1);
    localparam logic [AW-1:0]   ROW_SZ   = AW'(NPTS);

    typedef struct packed {
        phase_e                ph;
        logic [CNTW-1:0]       idx;
        logic [NW-1:0]         step;
        logic [NW-1:0]         nsteps;
        logic signed [CW-1:0]  coef;
        logic                  fin;
        logic [CYW-1:0]        cyc;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                   ld_en, st_en, last_step;
    logic [IDXW-1:0]        ld_idx;
    logic [NW-1:0]          row;
    logic [NPTS-1:0][W-1:0] regs;
    logic [NI-1:0][W-1:0]   pe_vals;

    // Six (NPTS-2) kernels, one per interior point, sharing one coefficient
    for (genvar i = 1; i < NPTS - 1; i++) begin : g_pe
        mesh_pe #(.W(W), .CW(CW), .FRAC(FRAC)) i_pe (
            .left  (regs[i-1]),
            .mid   (regs[i]),
            .right (regs[i+1]),
            .coef  (ctl_q.coef),
            .nxt   (pe_vals[i-1])
        );
    end

    mesh_regbank #(.NPTS(NPTS), .W(W)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (ld_en),
        .load_idx  (ld_idx),
        .load_data (rd_data),
        .step_en   (st_en),
        .step_vals (pe_vals),
        .regs      (regs)
    );

    always_comb begin
        ctl_d     = ctl_q;
        rd_en     = 1'b0;
        ld_en     = 1'b0;
        st_en     = 1'b0;
        wr_en     = 1'b0;
        ld_idx    = IDXW'(ctl_q.idx - CNT_ONE);
        rd_addr   = AW'(ctl_q.idx);
        last_step = (ctl_q.step == ctl_q.nsteps - STEP_ONE);
        row       = ctl_q.fin ? STEP_ONE : ctl_q.step + STEP_ONE;
        wr_addr   = AW'(row) * ROW_SZ + AW'(ctl_q.idx);
        wr_data   = regs[ctl_q.idx[IDXW-1:0]];

        if (ctl_q.ph != PH_IDLE) ctl_d.cyc = ctl_q.cyc + CYW'(1);

        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (start) begin
                    ctl_d.ph     = PH_LOAD;
                    ctl_d.idx    = '0;
                    ctl_d.step   = '0;
                    ctl_d.nsteps = steps;
                    ctl_d.coef   = coef;
                    ctl_d.fin    = final_only;
                    ctl_d.cyc    = '0;
                end
            end
            PH_LOAD: begin
                rd_en = (ctl_q.idx != CNT_FULL);
                ld_en = (ctl_q.idx != '0);
                if (ctl_q.idx == CNT_FULL) begin
                    ctl_d.idx = '0;
                    ctl_d.ph  = (ctl_q.nsteps == '0) ? PH_FIN : PH_STEP;
                end else begin
                    ctl_d.idx = ctl_q.idx + CNT_ONE;
                end
            end
            PH_STEP: begin
                st_en = 1'b1;
                if (!ctl_q.fin || last_step) begin
                    ctl_d.ph  = PH_SAVE;
                    ctl_d.idx = '0;
                end else begin
                    ctl_d.step = ctl_q.step + STEP_ONE;
                end
            end
            PH_SAVE: begin
                wr_en = 1'b1;
                if (ctl_q.idx == CNT_LAST) begin
                    ctl_d.idx = '0;
                    if (last_step) begin
                        ctl_d.ph = PH_FIN;
                    end else begin
                        ctl_d.ph   = PH_STEP;
                        ctl_d.step = ctl_q.step + STEP_ONE;
                    end
                end else begin
                    ctl_d.idx = ctl_q.idx + CNT_ONE;
                end
            end
            PH_FIN: begin
                ctl_d.ph = PH_IDLE;
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.ph <= PH_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy   = (ctl_q.ph != PH_IDLE);
    assign done   = (ctl_q.ph == PH_FIN);
    assign cycles = ctl_q.cyc;

    // R2: one memory port, so reads and writes never overlap
    a_r2_single_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    // R5: a row goes out on consecutive addresses without gaps
    a_r5_row_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctl_q.idx != CNT_LAST) |=>
            (wr_en && wr_addr == $past(wr_addr) + AW'(1)));

    // R7: a zero-step run never writes
    a_r7_no_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_q.nsteps == '0) |-> !wr_en);

    // R8: done lasts one cycle and ends the busy window
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9: the counter advances by one on every busy cycle before done
    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (cycles == $past(cycles) + CYW'(1)));

endmodule

// File: tb/test_heat_mesh_stepper.sv
module test_heat_mesh_stepper;
    localparam int CLK_PERIOD = 10;
    localparam int NPTS = 8;
    localparam int W    = 16;
    localparam int CW   = 16;
    localparam int FRAC = 8;
    localparam int NW   = 8;
    localparam int CYW  = 32;
    localparam int AW   = NW + 3;
    localparam int MEMD = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NW-1:0] steps = '0;
    logic [CW-1:0] coef = '0;
    logic final_only = 1'b0;
    logic busy, done, rd_en, wr_en;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [W-1:0] rd_data = '0;
    logic [W-1:0] wr_data;
    logic [CYW-1:0] cycles;

    logic [W-1:0] mem [MEMD];
    logic [W-1:0] exp_mem [MEMD];
    logic [AW-1:0] rd_log [16];
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic clr = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    heat_mesh_stepper i_heat_mesh_stepper (
        .clk(clk), .rst_n(rst_n), .start(start), .steps(steps), .coef(coef),
        .final_only(final_only), .busy(busy), .done(done), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cycles(cycles)
    );

    // RAM model with one cycle of read latency
    always @(posedge clk) begin
        if (clr) begin
            rd_cnt <= 0;
            wr_cnt <= 0;
        end else begin
            if (rd_en) begin
                rd_data <= mem[rd_addr];
                if (rd_cnt < 16) rd_log[rd_cnt] <= rd_addr;
                rd_cnt <= rd_cnt + 1;
            end
            if (wr_en) begin
                mem[wr_addr] <= wr_data;
                wr_cnt <= wr_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [W-1:0] kern(input logic [W-1:0] l, input logic [W-1:0] u,
                                          input logic [W-1:0] r, input logic [CW-1:0] c);
        longint lv, uv, rv, cv, p, s;
        lv = longint'($signed(l));
        uv = longint'($signed(u));
        rv = longint'($signed(r));
        cv = longint'($signed(c));
        p  = (lv + rv - 2 * uv) * cv;
        s  = p >>> FRAC;
        return u + s[W-1:0];
    endfunction

    task automatic run(input int n, input logic [CW-1:0] c, input bit fin,
                       input bit disturb, input string tag);
        logic [W-1:0] u [NPTS];
        logic [W-1:0] nu [NPTS];
        int exp_cyc, exp_wr, busy_n, bad, first_bad;
        bit got_done;
        for (int a = 0; a < MEMD; a++) begin
            mem[a] = W'($urandom);
            exp_mem[a] = mem[a];
        end
        for (int k = 0; k < NPTS; k++) u[k] = mem[k];
        for (int s = 0; s < n; s++) begin
            nu = u;
            for (int k = 1; k < NPTS - 1; k++) nu[k] = kern(u[k-1], u[k], u[k+1], c);
            u = nu;
            if (!fin) for (int k = 0; k < NPTS; k++) exp_mem[(s + 1) * NPTS + k] = u[k];
        end
        if (fin && n > 0) for (int k = 0; k < NPTS; k++) exp_mem[NPTS + k] = u[k];
        exp_cyc = (n == 0) ? 10 : (fin ? 18 + n : 10 + 9 * n);
        exp_wr  = (n == 0) ? 0 : (fin ? NPTS : NPTS * n);

        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        steps = NW'(n); coef = c; final_only = fin; start = 1'b1;
        @(negedge clk); start = 1'b0;
        busy_n = 0; got_done = 1'b0;
        for (int g = 0; g < 5000; g++) begin
            if (busy) busy_n++;
            if (done) begin got_done = 1'b1; break; end
            if (disturb && g == 3) begin
                start = 1'b1; steps = ~steps; coef = ~coef; final_only = ~final_only;
            end
            if (disturb && g == 4) start = 1'b0;
            @(negedge clk);
        end
        chk(got_done, "R8", {tag, " done seen"}, got_done, 1);
        chk(busy_n == exp_cyc, "R8", {tag, " busy window"}, busy_n, exp_cyc);
        @(negedge clk);
        chk(!done && !busy, "R8", {tag, " done single cycle"}, done, 0);
        chk(cycles == CYW'(exp_cyc), "R9", {tag, " cycle count"}, cycles, exp_cyc);
        chk(rd_cnt == NPTS, "R2", {tag, " read count"}, rd_cnt, NPTS);
        bad = 0;
        for (int k = 0; k < NPTS; k++) if (rd_log[k] != AW'(k)) bad++;
        chk(bad == 0, "R2", {tag, " read order"}, bad, 0);
        chk(wr_cnt == exp_wr, fin ? "R6" : (n == 0 ? "R7" : "R5"),
            {tag, " write count"}, wr_cnt, exp_wr);
        bad = 0; first_bad = 0;
        for (int a = 0; a < MEMD; a++) if (mem[a] !== exp_mem[a]) begin
            if (bad == 0) first_bad = a;
            bad++;
        end
        chk(bad == 0, "R3 R5 R6 R10", {tag, " memory image"},
            bad == 0 ? 0 : longint'(mem[first_bad]), bad == 0 ? 0 : longint'(exp_mem[first_bad]));
        if (n > 0) begin
            int rb;
            rb = fin ? NPTS : n * NPTS;
            chk(mem[rb] == mem[0] && mem[rb + NPTS - 1] == mem[NPTS - 1], "R4",
                {tag, " boundaries kept"}, mem[rb], mem[0]);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !rd_en && !wr_en, "R1", "idle outputs",
            {busy, done, rd_en, wr_en}, 0);
        chk(cycles == '0, "R1", "counter cleared", cycles, 0);

        run(0,   16'd100,  1'b0, 1'b0, "R7 zero steps");
        run(0,   16'd100,  1'b1, 1'b0, "R7 zero steps final");
        run(1,   16'd64,   1'b0, 1'b0, "one step");
        run(1,   16'd64,   1'b1, 1'b0, "one step final");
        run(5,   16'd0,    1'b0, 1'b0, "zero coef");
        run(9,   16'hFFE0, 1'b0, 1'b0, "negative coef");
        run(7,   16'h7FFF, 1'b1, 1'b0, "wrap");
        run(255, 16'd64,   1'b0, 1'b0, "max steps");
        run(255, 16'd100,  1'b1, 1'b0, "max steps final");
        run(6,   16'd90,   1'b0, 1'b1, "R10 disturb");
        run(6,   16'd90,   1'b1, 1'b1, "R10 disturb final");
        for (int t = 0; t < 12; t++) begin
            run($urandom_range(1, 24), CW'($urandom_range(0, 128)),
                1'($urandom_range(0, 1)), 1'b0, "random");
        end
        summary();
    end

endmodule